// File: doc/BRIEF.md
# Programmable performance counter bank

A monitor for a memory controller that counts hardware events in eight general-purpose counters. Each counter is 48 bits wide by default. Any counter can be pointed at any event through its own event-selection register. Event sources deliver single-cycle pulses, one input line per event code. One code is reserved for counting clock cycles.

Software drives the bank through a simple register port:

- It preloads or reads a counter with one 64-bit access.
- It chooses the event code for each counter.
- It enables counters one by one through an event-control register, and starts or stops all of them with a single global run bit.
- It handles overflow through mask, status and clear registers. When a counter rolls over, its status bit sets. A level interrupt output reports any status bit that is not masked.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter reads 0, the status register (0x52C) reads 0, the mask register (0x528) reads all ones (0xFF for eight counters), and irq is low.
- R2: Counter n is a 64-bit register at byte offset 0xE00 + 8*n. A write loads bits CNT_W-1:0 of bus_wdata. Bits 63:CNT_W always read as zero, and writes to those bits are ignored.
- R3: The event-selection register for counter n sits at 0xE74 + 4*n and holds an 8-bit code in bits 7:0, which read back as written. Code 0x00 counts every clock. A code c from 0x01 to 0x8F counts pulses on evt_in[c-1]; write traffic is code 0x83 and read traffic is code 0x84. Codes 0x90 and above never count.
- R4: Bit n of the event-control register at 0xE70 enables counter n. A counter whose bit is clear holds its value.
- R5: Bit 0 of the run register at 0xEA0 is the global enable. While it is clear no counter advances. Its other bits read as zero.
- R6: A counter advances by exactly one on a clock edge only when the global enable, its own enable and its selected event are all high at that edge.
- R7: A bus write to a counter on the same edge as an increment loads the written value, and the increment is lost.
- R8: A counter that advances from all ones wraps to zero and sets status bit n.
- R9: Mask bit n equal to 1 blocks status bit n from the interrupt. irq is the OR of all status bits whose mask bit is 0.
- R10: Writing 1 to bit n of the clear register at 0x530 clears status bit n. Bits written as 0 leave the status unchanged, and the clear register reads as zero.
- R11: A read request returns its data on bus_rdata with bus_rvalid high one clock after bus_rd is sampled. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write request, sampled on the rising edge |
| bus_rd | input | 1 | Read request, sampled on the rising edge |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after a read request |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds read data |
| evt_in | input | NUM_EVT-1 (143) | Event pulses; bit c-1 carries event code c |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the bank with eight counters, the full 144-code event space and a 10-bit counter width. The short width lets the counter that counts cycles roll over within a few cycles of a preload, and the bench checks that every bit above bit 9 reads as zero.

The bench then steps through every valid event code. For each code it sends pulses on the selected line and on all the other lines, and checks that only the selected pulses are counted. The codes just past the valid range are run in the same window.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CNT_BASE  = 12'hE00;
  localparam logic [ADDR_W-1:0] OFF_ECTL      = 12'hE70;
  localparam logic [ADDR_W-1:0] OFF_TYPE_BASE = 12'hE74;
  localparam logic [ADDR_W-1:0] OFF_RUN       = 12'hEA0;
  localparam logic [ADDR_W-1:0] OFF_MASK      = 12'h528;
  localparam logic [ADDR_W-1:0] OFF_STAT      = 12'h52C;
  localparam logic [ADDR_W-1:0] OFF_CLR       = 12'h530;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CNT,
    RK_TYPE,
    RK_ECTL,
    RK_RUN,
    RK_MASK,
    RK_STAT,
    RK_CLR
  } reg_kind_e;

endpackage

// File: rtl/pcb_reg_decode.sv
module pcb_reg_decode
  import pcb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);
  localparam logic [ADDR_W-1:0] TYP_SPAN = ADDR_W'(4 * NUM_CNT);

  logic [ADDR_W-1:0] cnt_off;
  logic [ADDR_W-1:0] typ_off;

  always_comb begin
    cnt_off = addr - OFF_CNT_BASE;
    typ_off = addr - OFF_TYPE_BASE;
    kind    = RK_NONE;
    idx     = '0;
    if ((cnt_off < CNT_SPAN) && (cnt_off[2:0] == 3'b000)) begin
      kind = RK_CNT;
      idx  = cnt_off[IDX_W+2:3];
    end else if ((typ_off < TYP_SPAN) && (typ_off[1:0] == 2'b00)) begin
      kind = RK_TYPE;
      idx  = typ_off[IDX_W+1:2];
    end else if (addr == OFF_ECTL) begin
      kind = RK_ECTL;
    end else if (addr == OFF_RUN) begin
      kind = RK_RUN;
    end else if (addr == OFF_MASK) begin
      kind = RK_MASK;
    end else if (addr == OFF_STAT) begin
      kind = RK_STAT;
    end else if (addr == OFF_CLR) begin
      kind = RK_CLR;
    end
  end

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CNT_W   = 48,
  parameter int EVT_W   = 8,
  parameter int NUM_EVT = 144
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               cnt_en,
  input  logic [EVT_W-1:0]   evt_code,
  input  logic [NUM_EVT-2:0] evt_in,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               inc,
  output logic               wrap
);

  localparam int SEL_N = 2 ** EVT_W;

  logic [SEL_N-1:0] evt_all;
  logic             evt_sel;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ld;

  // Code 0 is the free-running cycle event; codes past NUM_EVT-1 select zero.
  always_comb begin
    evt_all              = '0;
    evt_all[0]           = 1'b1;
    evt_all[NUM_EVT-1:1] = evt_in;
    evt_sel              = evt_all[evt_code];
  end

  always_comb begin
    inc    = glb_en & cnt_en & evt_sel;
    wrap   = inc & ~wr_en & (&cnt_q);
    cnt_ld = wr_en | inc;
    cnt_d  = cnt_q;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pcb_irq.sv
module pcb_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_CNT-1:0] mask_bits,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_bits,
  input  logic [NUM_CNT-1:0] wrap,
  output logic [NUM_CNT-1:0] mask_q,
  output logic [NUM_CNT-1:0] sts_q,
  output logic               irq
);

  logic [NUM_CNT-1:0] clr_sel;
  logic [NUM_CNT-1:0] sts_d;
  logic               sts_ld;

  always_comb begin
    clr_sel = clr_we ? clr_bits : '0;
    sts_d   = (sts_q & ~clr_sel) | wrap;
    sts_ld  = clr_we | (|wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ld) begin
      sts_q <= sts_d;
    end
  end

  assign irq = |(sts_q & ~mask_q);

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int EVT_W   = 8,
  parameter int NUM_EVT = 144,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_EVT-2:0] evt_in,
  output logic               irq
);

  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;

  logic [EVT_W-1:0]   evt_type_q [NUM_CNT];
  logic [CNT_W-1:0]   cnt_q      [NUM_CNT];
  logic [NUM_CNT-1:0] ectl_q;
  logic               glb_en_q;

  logic [NUM_CNT-1:0]       cnt_wr;
  logic [NUM_CNT-1:0]       type_we;
  logic [NUM_CNT-1:0]       cnt_inc;
  logic [NUM_CNT-1:0]       cnt_wrap;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     ectl_we;
  logic                     run_we;
  logic                     mask_we;
  logic                     clr_we;

  logic [NUM_CNT-1:0] mask_q;
  logic [NUM_CNT-1:0] sts_q;

  logic [DATA_W-1:0]  rdata_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  pcb_reg_decode #(.NUM_CNT(NUM_CNT)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  always_comb begin
    ectl_we = bus_wr && (kind == RK_ECTL);
    run_we  = bus_wr && (kind == RK_RUN);
    mask_we = bus_wr && (kind == RK_MASK);
    clr_we  = bus_wr && (kind == RK_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ectl_q <= '0;
    end else if (ectl_we) begin
      ectl_q <= bus_wdata[NUM_CNT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
    end else if (run_we) begin
      glb_en_q <= bus_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_wr[i]  = bus_wr && (kind == RK_CNT)  && (idx == IDX_W'(i));
    assign type_we[i] = bus_wr && (kind == RK_TYPE) && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_type_q[i] <= '0;
      end else if (type_we[i]) begin
        evt_type_q[i] <= bus_wdata[EVT_W-1:0];
      end
    end

    pcb_counter #(
      .CNT_W   (CNT_W),
      .EVT_W   (EVT_W),
      .NUM_EVT (NUM_EVT)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en   (glb_en_q),
      .cnt_en   (ectl_q[i]),
      .evt_code (evt_type_q[i]),
      .evt_in   (evt_in),
      .wr_en    (cnt_wr[i]),
      .wr_data  (bus_wdata[CNT_W-1:0]),
      .cnt_q    (cnt_q[i]),
      .inc      (cnt_inc[i]),
      .wrap     (cnt_wrap[i])
    );

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
  end

  pcb_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_bits (bus_wdata[NUM_CNT-1:0]),
    .clr_we    (clr_we),
    .clr_bits  (bus_wdata[NUM_CNT-1:0]),
    .wrap      (cnt_wrap),
    .mask_q    (mask_q),
    .sts_q     (sts_q),
    .irq       (irq)
  );

  always_comb begin
    rdata_d = '0;
    case (kind)
      RK_CNT:  rdata_d = DATA_W'(cnt_q[idx]);
      RK_TYPE: rdata_d = DATA_W'(evt_type_q[idx]);
      RK_ECTL: rdata_d = DATA_W'(ectl_q);
      RK_RUN:  rdata_d = DATA_W'(glb_en_q);
      RK_MASK: rdata_d = DATA_W'(mask_q);
      RK_STAT: rdata_d = DATA_W'(sts_q);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     glb_en,
  input logic [NUM_CNT-1:0]       inc,
  input logic [NUM_CNT-1:0]       cnt_wr,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       sts,
  input logic [NUM_CNT-1:0]       mask,
  input logic                     irq,
  input logic                     clr_we,
  input logic [NUM_CNT-1:0]       clr_bits,
  input logic                     rvalid,
  input logic [63:0]              rdata
);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    // R6: a counted event moves the counter up by one
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && !cnt_wr[i]) |=>
        (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1));

    // R5: with the run bit clear only a bus write can change a counter
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !cnt_wr[i]) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

    // R8: advancing from all ones gives zero and a set status bit
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && !cnt_wr[i] && (&cnt_flat[i*CNT_W +: CNT_W])) |=>
        (sts[i] && (cnt_flat[i*CNT_W +: CNT_W] == '0)));

    // R10: a clear with no concurrent wrap drops the status bit
    p_clear_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[i] &&
       !(inc[i] && !cnt_wr[i] && (&cnt_flat[i*CNT_W +: CNT_W]))) |=> !sts[i]);
  end

  // R9: all bits masked keeps the interrupt low
  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R9: an interrupt needs a pending status bit
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts));

  // R2: nothing above bit 47 ever appears on a read
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata[63:48] == 16'h0));

endmodule

bind perf_counter_bank pcb_checker #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glb_en   (glb_en_q),
  .inc      (cnt_inc),
  .cnt_wr   (cnt_wr),
  .cnt_flat (cnt_flat),
  .sts      (sts_q),
  .mask     (mask_q),
  .irq      (irq),
  .clr_we   (clr_we),
  .clr_bits (bus_wdata[NUM_CNT-1:0]),
  .rvalid   (bus_rvalid),
  .rdata    (bus_rdata)
);

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb;

  localparam int NC    = 8;
  localparam int CW    = 10;
  localparam int NE    = 144;
  localparam int EINW  = NE - 1;
  localparam logic [63:0] CMASK = (64'd1 << CW) - 1;

  localparam logic [11:0] A_CNT  = 12'hE00;
  localparam logic [11:0] A_TYPE = 12'hE74;
  localparam logic [11:0] A_ECTL = 12'hE70;
  localparam logic [11:0] A_RUN  = 12'hEA0;
  localparam logic [11:0] A_MASK = 12'h528;
  localparam logic [11:0] A_STAT = 12'h52C;
  localparam logic [11:0] A_CLR  = 12'h530;

  logic            clk;
  logic            rst_n;
  logic            bus_wr;
  logic            bus_rd;
  logic [11:0]     bus_addr;
  logic [63:0]     bus_wdata;
  logic [63:0]     bus_rdata;
  logic            bus_rvalid;
  logic [EINW-1:0] evt_in;
  logic            irq;

  int checks;
  int fails;
  bit done;

  perf_counter_bank #(
    .NUM_CNT (NC),
    .CNT_W   (CW),
    .EVT_W   (8),
    .NUM_EVT (NE),
    .DATA_W  (64)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .evt_in     (evt_in),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  function automatic logic [EINW-1:0] pat(input int g);
    logic [EINW-1:0] p;
    p = '0;
    if (g == 5) begin
      p = '1;
    end else begin
      if (g % 3 == 0) p[8'h84-1] = 1'b1;
      if (g % 2 == 0) p[8'h83-1] = 1'b1;
      if (g < 2)      p[8'h8F-1] = 1'b1;
    end
    return p;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [63:0] d;
    logic        v;
    logic [63:0] exp_c [NC];
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq after reset", 64'(irq), 64'd0);
    rd(A_MASK, d, v); chk("R1 mask reset", d, 64'hFF);
    rd(A_STAT, d, v); chk("R1 status reset", d, 64'd0);
    for (int i = 0; i < NC; i++) begin
      rd(A_CNT + 12'(8*i), d, v); chk("R1 counter reset", d, 64'd0);
    end

    // R11: read latency and valid flag, unmapped offset
    rd(12'h100, d, v);
    chk("R11 rvalid", 64'(v), 64'd1);
    chk("R11 unmapped reads zero", d, 64'd0);

    // R2: preload and readback of every counter, upper bits dropped
    for (int i = 0; i < NC; i++) begin
      logic [63:0] val;
      val = 64'hFFFF_A5A5_0000_0000 | 64'(i*37 + 5) | (64'(i) << 9);
      wr(A_CNT + 12'(8*i), val);
      rd(A_CNT + 12'(8*i), d, v);
      chk("R2 counter preload readback", d, val & CMASK);
    end

    // R3: event-selection readback for every counter
    for (int i = 0; i < NC; i++) begin
      wr(A_TYPE + 12'(4*i), 64'hFFFF_FF00 | 64'(8'h10 + 8'(3*i)));
      rd(A_TYPE + 12'(4*i), d, v);
      chk("R3 event code readback", d, 64'(8'h10 + 8'(3*i)));
    end

    // R10: clear register reads zero
    rd(A_CLR, d, v); chk("R10 clear reads zero", d, 64'd0);

    // R5: only bit 0 of the run register is kept
    wr(A_RUN, 64'hFFFF_FFFE);
    rd(A_RUN, d, v); chk("R5 run upper bits read zero", d, 64'd0);

    // R5: with run clear a cycle counter does not advance
    wr(A_CNT, 64'd0);
    wr(A_TYPE, 64'h00);
    wr(A_ECTL, 64'h01);
    repeat (20) @(negedge clk);
    rd(A_CNT, d, v); chk("R5 stopped counter holds", d, 64'd0);

    // Window test: R3 R4 R6 R8
    wr(A_CNT + 12'd0,  64'd0);   wr(A_TYPE + 12'd0,  64'h00);
    wr(A_CNT + 12'd8,  64'd77);  wr(A_TYPE + 12'd4,  64'h00);
    wr(A_CNT + 12'd16, 64'd1021); wr(A_TYPE + 12'd8, 64'h00);
    wr(A_CNT + 12'd24, 64'd0);   wr(A_TYPE + 12'd12, 64'h84);
    wr(A_CNT + 12'd32, 64'd0);   wr(A_TYPE + 12'd16, 64'h83);
    wr(A_CNT + 12'd40, 64'd0);   wr(A_TYPE + 12'd20, 64'h95);
    wr(A_CNT + 12'd48, 64'd0);   wr(A_TYPE + 12'd24, 64'h90);
    wr(A_CNT + 12'd56, 64'd0);   wr(A_TYPE + 12'd28, 64'h8F);
    wr(A_ECTL, 64'hFD);
    exp_c[0] = 64'd8;
    exp_c[1] = 64'd77;
    exp_c[2] = (64'd1021 + 64'd8) & CMASK;
    exp_c[3] = 0; exp_c[4] = 0; exp_c[5] = 0; exp_c[6] = 0; exp_c[7] = 0;
    for (int g = 0; g < 6; g++) begin
      logic [EINW-1:0] p;
      p = pat(g);
      exp_c[3] += 64'(p[8'h84-1]);
      exp_c[4] += 64'(p[8'h83-1]);
      exp_c[7] += 64'(p[8'h8F-1]);
    end
    wr(A_RUN, 64'h1);
    for (int g = 0; g < 6; g++) begin
      evt_in = pat(g);
      @(negedge clk);
    end
    evt_in = '0;
    wr(A_RUN, 64'h0);
    rd(A_CNT + 12'd0,  d, v); chk("R6 cycle code counts run edges", d, exp_c[0]);
    rd(A_CNT + 12'd8,  d, v); chk("R4 disabled counter holds", d, exp_c[1]);
    rd(A_CNT + 12'd16, d, v); chk("R8 wrapped counter value", d, exp_c[2]);
    rd(A_CNT + 12'd24, d, v); chk("R3 read-traffic code 0x84", d, exp_c[3]);
    rd(A_CNT + 12'd32, d, v); chk("R3 write-traffic code 0x83", d, exp_c[4]);
    rd(A_CNT + 12'd40, d, v); chk("R3 invalid code 0x95 silent", d, 64'd0);
    rd(A_CNT + 12'd48, d, v); chk("R3 invalid code 0x90 silent", d, 64'd0);
    rd(A_CNT + 12'd56, d, v); chk("R3 last valid code 0x8F", d, exp_c[7]);
    rd(A_STAT, d, v); chk("R8 status after wrap", d, 64'h04);

    // R9: mask behaviour
    chk("R9 irq masked", 64'(irq), 64'd0);
    wr(A_MASK, 64'hFB);
    chk("R9 irq unmasked", 64'(irq), 64'd1);
    wr(A_MASK, 64'hFF);
    chk("R9 irq remasked", 64'(irq), 64'd0);
    wr(A_MASK, 64'hFB);

    // R10: clear behaviour
    wr(A_CLR, 64'h0);
    rd(A_STAT, d, v); chk("R10 zero clear bits ignored", d, 64'h04);
    chk("R10 irq still pending", 64'(irq), 64'd1);
    wr(A_CLR, 64'h04);
    rd(A_STAT, d, v); chk("R10 status cleared", d, 64'd0);
    chk("R10 irq after clear", 64'(irq), 64'd0);

    // R7: bus write beats an increment on the same edge
    wr(A_CNT, 64'd0);
    wr(A_TYPE, 64'h00);
    wr(A_ECTL, 64'h01);
    wr(A_RUN, 64'h1);
    wr(A_CNT, 64'd300);
    rd(A_CNT, d, v); chk("R7 write wins over increment", d, 64'd301);
    wr(A_RUN, 64'h0);

    // R3 R6: sweep every valid event code, other lines must not count
    for (int c = 1; c < NE; c++) begin
      int n;
      logic [EINW-1:0] one;
      n = c % NC;
      one = '0;
      one[c-1] = 1'b1;
      wr(A_TYPE + 12'(4*n), 64'(c));
      wr(A_CNT + 12'(8*n), 64'd0);
      wr(A_ECTL, 64'd1 << n);
      wr(A_RUN, 64'h1);
      evt_in = one;
      @(negedge clk);
      evt_in = ~one;
      @(negedge clk);
      evt_in = one;
      @(negedge clk);
      evt_in = '0;
      wr(A_RUN, 64'h0);
      rd(A_CNT + 12'(8*n), d, v);
      chk("R3 R6 event code sweep", d, 64'd2);
    end

    finish_run();
  end

endmodule